// File: doc/BRIEF.md
# Cascaded System Tick Flag Generator

This block turns a free-running 16-bit counter into a periodic system tick. The tick is not made by reloading the counter. A compare value is matched against the counter, and on every match the compare value moves forward by one tick period, wrapping at 2^16. The counter itself is never cleared, so the tick keeps its phase even when the tick is disabled.

Each enabled tick drives a cascade of three sub-counters. A millisecond accumulator adds the tick length, in milliseconds, on every tick. When the sum reaches the fast period, the accumulator subtracts that period and keeps the remainder. This raises a 10 ms event, which steps a middle counter. That counter raises a 250 ms event after 25 such events, and 4 of those raise a 1 s event. Each event sets a sticky flag, and the flag stays set until a consumer clears it with a strobe.

Top module: `sysTickFlags`

## Requirements
- R1: After reset is released, the first `tickPulse` is high in the cycle after the `TICK_CYCLES+1`-th rising clock edge. The counter reads 0 at the first edge and advances by one per edge, and the first compare value equals `TICK_CYCLES`.
- R2: After every match the compare value advances by `TICK_CYCLES` modulo 2^16. Matches therefore recur exactly every `TICK_CYCLES` clocks, including across the 16-bit counter wrap.
- R3: While `tickEn` is low, no `tickPulse` is produced and the cascade does not advance. The compare value still re-arms, so the tick phase is unchanged when `tickEn` returns high.
- R4: On every tick the millisecond accumulator adds `TICK_MS`. When the sum is at least 10, it subtracts 10, keeps the remainder and sets `flag10ms`. No flag rises except in a cycle where `tickPulse` is high.
- R5: Every 25th 10 ms event sets `flag250ms`. The middle counter subtracts 25 when it reaches 25.
- R6: Every 4th 250 ms event sets `flag1s`. A 1 s event always coincides with a 250 ms event and a 10 ms event.
- R7: A set flag stays high until its own clear strobe is high at a clock edge.
- R8: If a flag's set event and its clear strobe fall on the same edge, the flag ends up set.
- R9: A clear strobe affects only its own flag.
- R10: During reset, all flags and `tickPulse` are low, and the accumulators are cleared.
- R11: `tickPulse` is exactly one clock cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also increments the free-running counter |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Lets compare matches produce ticks |
| clr10ms | input | 1 | Clear strobe for the 10 ms flag |
| clr250ms | input | 1 | Clear strobe for the 250 ms flag |
| clr1s | input | 1 | Clear strobe for the 1 s flag |
| tickPulse | output | 1 | One-cycle pulse on each enabled tick |
| flag10ms | output | 1 | Sticky 10 ms event flag |
| flag250ms | output | 1 | Sticky 250 ms event flag |
| flag1s | output | 1 | Sticky 1 s event flag |

## Verification
The assertions check on every cycle:
- the spacing between compare matches;
- the width of the tick pulse;
- that a tick appears only when enabled;
- the bound on the accumulator remainder;
- that flags rise only on ticks;
- that flags hold until cleared, and that the levels nest (1 s implies 250 ms, 250 ms implies 10 ms).

Only the bench's reference model can show the exact cycle of the first tick and the remainder-preserving arithmetic, with a tick length that does not divide 10. The same applies to correct behaviour across the 16-bit wrap, phase retention through a disabled window, and the outcome when a set and a clear coincide.

// File: rtl/sysTickPkg.sv
package sysTickPkg;
  localparam int NUM_FLAGS = 3;
  typedef struct packed {
    logic                 tick;
    logic [NUM_FLAGS-1:0] clr;  // [0]=10ms [1]=250ms [2]=1s
  } tickCmd_t;
endpackage

// File: rtl/sysTickTimebase.sv
module sysTickTimebase
  import sysTickPkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int TICK_CYCLES = 2000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tickEn,
  input  logic [NUM_FLAGS-1:0] clrIn,
  output tickCmd_t             cmd
);
  localparam logic [CNT_W-1:0] STEP = CNT_W'(TICK_CYCLES);

  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] cmpQ;
  logic             match;

  assign match     = (cntQ == cmpQ);
  assign cmd.tick  = match & tickEn;
  assign cmd.clr   = clrIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
      cmpQ <= STEP;
    end else begin
      cntQ <= cntQ + 1'b1;
      if (match) cmpQ <= cmpQ + STEP;
    end
  end

  // Gap counter used only by the spacing check.
  logic [CNT_W-1:0] gapQ;
  logic             seenQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gapQ  <= '0;
      seenQ <= 1'b0;
    end else if (match) begin
      gapQ  <= '0;
      seenQ <= 1'b1;
    end else begin
      gapQ  <= gapQ + 1'b1;
    end
  end

  assert_match_spacing_R2: assert property (@(posedge clk) disable iff (!rstN)
    (match && seenQ) |-> (gapQ == CNT_W'(TICK_CYCLES - 1)));
  assert_single_match_R11: assert property (@(posedge clk) disable iff (!rstN)
    match |=> !match);

  initial begin
    assert_period_fits_R2: assert (TICK_CYCLES > 1 && TICK_CYCLES < (1 << CNT_W));
  end
endmodule

// File: rtl/sysTickCascade.sv
module sysTickCascade
  import sysTickPkg::*;
#(
  parameter int TICK_MS       = 2,
  parameter int MS_PER_FAST   = 10,
  parameter int FAST_PER_MID  = 25,
  parameter int MID_PER_SLOW  = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  tickCmd_t             cmd,
  output logic                 tickPulse,
  output logic [NUM_FLAGS-1:0] flags
);
  localparam int ACC_W  = $clog2(MS_PER_FAST + TICK_MS);
  localparam int MID_W  = $clog2(FAST_PER_MID + 1);
  localparam int SLOW_W = $clog2(MID_PER_SLOW + 1);

  logic [ACC_W-1:0]  accQ, accSum;
  logic [MID_W-1:0]  midQ, midNext;
  logic [SLOW_W-1:0] slowQ, slowNext;
  logic [NUM_FLAGS-1:0] fire;

  always_comb begin
    accSum   = accQ + ACC_W'(TICK_MS);
    midNext  = midQ + 1'b1;
    slowNext = slowQ + 1'b1;
    fire[0]  = cmd.tick && (accSum >= ACC_W'(MS_PER_FAST));
    fire[1]  = fire[0] && (midNext >= MID_W'(FAST_PER_MID));
    fire[2]  = fire[1] && (slowNext >= SLOW_W'(MID_PER_SLOW));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ      <= '0;
      midQ      <= '0;
      slowQ     <= '0;
      tickPulse <= 1'b0;
    end else begin
      tickPulse <= cmd.tick;
      if (cmd.tick) accQ  <= fire[0] ? accSum - ACC_W'(MS_PER_FAST) : accSum;
      if (fire[0])  midQ  <= fire[1] ? midNext - MID_W'(FAST_PER_MID) : midNext;
      if (fire[1])  slowQ <= fire[2] ? slowNext - SLOW_W'(MID_PER_SLOW) : slowNext;
    end
  end

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : gFlag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) flags[i] <= 1'b0;
      else       flags[i] <= fire[i] | (flags[i] & ~cmd.clr[i]);
    end

    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
      (flags[i] && !cmd.clr[i]) |=> flags[i]);
    assert_flag_on_tick_R4: assert property (@(posedge clk) disable iff (!rstN)
      $rose(flags[i]) |-> tickPulse);
  end

  assert_acc_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    accQ < ACC_W'(MS_PER_FAST));
  assert_nest_mid_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flags[1]) |-> flags[0]);
  assert_nest_slow_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flags[2]) |-> flags[1]);
  assert_pulse_width_R11: assert property (@(posedge clk) disable iff (!rstN)
    tickPulse |=> !tickPulse);

  initial begin
    assert_tick_ms_R4: assert (TICK_MS >= 1 && TICK_MS <= MS_PER_FAST);
  end
endmodule

// File: rtl/sysTickFlags.sv
module sysTickFlags
  import sysTickPkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int TICK_CYCLES = 2000,
  parameter int TICK_MS     = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic tickEn,
  input  logic clr10ms,
  input  logic clr250ms,
  input  logic clr1s,
  output logic tickPulse,
  output logic flag10ms,
  output logic flag250ms,
  output logic flag1s
);
  tickCmd_t             cmd;
  logic [NUM_FLAGS-1:0] flags;

  sysTickTimebase #(.CNT_W(CNT_W), .TICK_CYCLES(TICK_CYCLES)) uTimebase (
    .clk(clk), .rstN(rstN), .tickEn(tickEn),
    .clrIn({clr1s, clr250ms, clr10ms}), .cmd(cmd)
  );

  sysTickCascade #(.TICK_MS(TICK_MS)) uCascade (
    .clk(clk), .rstN(rstN), .cmd(cmd), .tickPulse(tickPulse), .flags(flags)
  );

  assign flag10ms  = flags[0];
  assign flag250ms = flags[1];
  assign flag1s    = flags[2];

  assert_tick_enabled_R3: assert property (@(posedge clk) disable iff (!rstN)
    tickPulse |-> $past(tickEn));
endmodule

// File: tb/sim_sysTickFlags.sv
module sim_sysTickFlags;
  localparam int TCYC = 20;
  localparam int TMS  = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 1'b0, clr10ms = 1'b0, clr250ms = 1'b0, clr1s = 1'b0;
  logic tickPulse, flag10ms, flag250ms, flag1s;

  always #2.5 clk = ~clk;  // 200 MHz

  sysTickFlags #(.CNT_W(16), .TICK_CYCLES(TCYC), .TICK_MS(TMS)) u0 (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .clr10ms(clr10ms),
    .clr250ms(clr250ms), .clr1s(clr1s), .tickPulse(tickPulse),
    .flag10ms(flag10ms), .flag250ms(flag250ms), .flag1s(flag1s)
  );

  int compared = 0, mismatched = 0;
  bit done = 0;
  string phase = "R10 reset";

  // Behavioural reference.
  int mCnt = 0, mCmp = TCYC, mAcc = 0, mMid = 0, mSlow = 0;
  bit mTick = 0, mF10 = 0, mF250 = 0, mF1 = 0;
  int ticksSeen = 0, f1Events = 0;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCnt = 0; mCmp = TCYC; mAcc = 0; mMid = 0; mSlow = 0;
      mTick = 0; mF10 = 0; mF250 = 0; mF1 = 0;
    end else begin
      bit hit, e10, e250, e1;
      hit = (mCnt == mCmp);
      mCnt = (mCnt + 1) % 65536;
      if (hit) mCmp = (mCmp + TCYC) % 65536;
      mTick = hit && tickEn;
      e10 = 0; e250 = 0; e1 = 0;
      if (mTick) begin
        mAcc += TMS;
        if (mAcc >= 10) begin
          mAcc -= 10; e10 = 1; mMid++;
          if (mMid >= 25) begin
            mMid -= 25; e250 = 1; mSlow++;
            if (mSlow >= 4) begin mSlow -= 4; e1 = 1; end
          end
        end
      end
      mF10  = e10  || (mF10  && !clr10ms);
      mF250 = e250 || (mF250 && !clr250ms);
      mF1   = e1   || (mF1   && !clr1s);
      if (mTick) ticksSeen++;
      if (e1) f1Events++;
    end
  end

  task automatic check1(string sig, string req, logic act, bit exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s [%s] t=%0t actual=%b expected=%b", req, sig, phase, $time, act, exp);
    end
  endtask

  task automatic compareAll();
    check1("tickPulse", "R1 R2 R3 R11", tickPulse, mTick);
    check1("flag10ms",  "R4 R7 R8 R9", flag10ms,  mF10);
    check1("flag250ms", "R5 R7 R8 R9", flag250ms, mF250);
    check1("flag1s",    "R6 R7 R8 R9", flag1s,    mF1);
  endtask

  task automatic run(int n, int clrMode);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      compareAll();
      case (clrMode)
        0: {clr10ms, clr250ms, clr1s} = 3'b000;          // R7 hold
        1: {clr10ms, clr250ms, clr1s} = 3'b111;          // R8 held clears
        2: begin                                          // R9 only 10ms
             clr10ms = ($urandom_range(0, 3) == 0); clr250ms = 0; clr1s = 0;
           end
        default: begin
             clr10ms  = ($urandom_range(0, 7) == 0);
             clr250ms = ($urandom_range(0, 7) == 0);
             clr1s    = ($urandom_range(0, 7) == 0);
           end
      endcase
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      mismatched++; compared++;
      $display("FAIL watchdog expired in phase %s", phase);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (4) begin @(negedge clk); compareAll(); end  // R10
    tickEn = 1;
    rstN = 1;
    phase = "R1 first tick";
    // R1: first pulse visible after TCYC+1 edges.
    for (int k = 1; k <= TCYC + 1; k++) begin
      @(negedge clk);
      check1("tickPulse", "R1", tickPulse, (k == TCYC + 1));
    end
    phase = "R4 R5 R6 R7 no clears";
    run(8000, 0);
    phase = "R9 clear 10ms only";
    run(3000, 2);
    phase = "R8 clears held";
    run(8000, 1);
    phase = "R3 disabled";
    tickEn = 0;
    run(157, 3);
    tickEn = 1;
    phase = "R2 random clears across wrap";
    run(70000, 3);
    phase = "R11 final";
    run(100, 0);
    compared++;
    if (f1Events < 5) begin
      mismatched++;
      $display("FAIL R6 too few 1s events actual=%0d expected>=5", f1Events);
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule